// File: doc/BRIEF.md
# PCM Serial Port with Automatic Frame-Sync Detection

This block is the full-duplex serial link between a voice conversion core and a host signal processor. In each frame it sends one 8-bit code and receives one 8-bit code, most significant (sign) bit first. The send side drives a data line that can be switched off, with a separate output-enable so the pad can be three-stated. It also drives an active-low time-slot strobe that models an open-drain pin. The receive side assembles a word from the incoming line and hands it to the core as a parallel word with a one-cycle valid pulse.

The bit clock and both frame syncs are sampled by a faster system clock, and their edges are detected inside the block. The port measures how wide the transmit sync is and chooses between short framing (sync one or two bit periods wide) and long framing (three or more). In long framing each edge of the output window is placed at whichever of the frame-sync edge and the bit-clock edge comes later. The core loads the next transmit code into a holding register at any time. The shifter copies that register once, when a frame starts.

Top module: `pcm_port_top`

## Requirements
- R1: After reset the output enable is 0, the strobe is 1, short framing is selected and no receive valid is given.
- R2: In short framing, a transmit sync sampled high on a falling bit-clock edge makes the next rising edge enable the output and drive bit 7. The next seven rising edges drive bits 6 to 0. The falling edge after the eighth bit turns the output off.
- R3: The framing mode is updated when the transmit sync falls. It becomes long if the sync was high on at least 3 falling bit-clock edges and short if it was high on 1 or 2. The width of the receive sync never changes the mode.
- R4: In long framing the output turns on at the later of the transmit-sync rise and a bit-clock rise, and it drives bit 7 first. A sync that rises while the bit clock is low leaves the output off until the next rising edge.
- R5: In long framing the output turns off at the later of the falling edge after the eighth bit and the transmit sync going low.
- R6: In short framing, a receive sync sampled high on a falling edge makes the next eight falling edges capture bits 7 down to 0.
- R7: In long framing, a rising receive sync makes the next eight falling edges capture bits 7 down to 0.
- R8: Each received word appears on the parallel output with a valid pulse exactly one system cycle long.
- R9: The strobe is low exactly while the transmit output is enabled.
- R10: The transmitted word is the content of the holding register when the frame starts. A load during shifting has no effect on the current word and is sent in the next frame.
- R11: A sync accepted in the middle of a word restarts that direction's bit count, so the bits received before it are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, faster than the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock |
| tx_fs_i | input | 1 | Transmit frame sync |
| tx_word_i | input | 8 | Next code from the core |
| tx_load_i | input | 1 | Writes tx_word_i into the holding register |
| tx_sd_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Enable for the three-state transmit pad |
| slot_n_o | output | 1 | Time-slot strobe, active low |
| rx_fs_i | input | 1 | Receive frame sync |
| rx_sd_i | input | 1 | Serial receive data |
| rx_word_o | output | 8 | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse when rx_word_o is updated |
| long_mode_o | output | 1 | 1 when long framing is in use |

## Verification
The hardest case to reach is a long-framed transmit sync that rises while the bit clock is low. The output must then stay off until the bit clock rises. The bench reaches this by first training the port into long mode, then driving the sync in the middle of the low phase and probing the enable before the next rising edge. A second hard case is a tail held open by a transmit sync that lasts longer than the word. A third is a sync repeated in the middle of a word. Each of these gets its own sequence of frames, and the scoreboard compares the reassembled words against what the bench expects.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {
    FRM_SHORT = 1'b0,
    FRM_LONG  = 1'b1
  } frame_mode_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_ARMED,
    TX_SHIFT,
    TX_TAIL
  } tx_state_e;
endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det #(
  parameter int unsigned N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    assign rise_o[g] =  lvl_i[g] & ~lvl_q[g];
    assign fall_o[g] = ~lvl_i[g] &  lvl_q[g];
  end
endmodule

// File: rtl/pcm_frame_detect.sv
module pcm_frame_detect
  import pcm_port_pkg::*;
#(
  parameter int unsigned LONG_MIN = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bclk_fall_i,
  input  logic        fs_lvl_i,
  input  logic        fs_fall_i,
  output frame_mode_e mode_o
);
  localparam int unsigned CW = $clog2(LONG_MIN + 1);
  localparam logic [CW-1:0] WID_SAT = CW'(LONG_MIN);

  logic [CW-1:0] wid_q;
  frame_mode_e   mode_q;

  // width counted in falling bit-clock edges seen with sync high, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wid_q  <= '0;
      mode_q <= FRM_SHORT;
    end else if (fs_fall_i) begin
      mode_q <= (wid_q >= WID_SAT) ? FRM_LONG : FRM_SHORT;
      wid_q  <= '0;
    end else if (bclk_fall_i && fs_lvl_i && wid_q != WID_SAT) begin
      wid_q <= wid_q + 1'b1;
    end
  end

  assign mode_o = mode_q;

  AST_MODE_ON_SYNC_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> $past(fs_fall_i)); // R3
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
  import pcm_port_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  frame_mode_e       mode_i,
  input  logic              bclk_lvl_i,
  input  logic              bclk_rise_i,
  input  logic              bclk_fall_i,
  input  logic              fs_lvl_i,
  input  logic              fs_rise_i,
  input  logic              fs_fall_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_i,
  output logic              sd_o,
  output logic              oe_o
);
  localparam int unsigned CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] hold_q, sh_q;
  logic [CW-1:0]     cnt_q;
  tx_state_e         st_q;
  logic              long_m, go_now, arm;

  assign long_m = (mode_i == FRM_LONG);
  // long framing: sync rising while bit clock is already high starts at once
  assign go_now = long_m & fs_rise_i & bclk_lvl_i;
  assign arm    = long_m ? (fs_rise_i & ~bclk_lvl_i) : (bclk_fall_i & fs_lvl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (load_i) hold_q <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TX_IDLE;
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (go_now) begin
      st_q  <= TX_SHIFT;
      sh_q  <= hold_q;
      cnt_q <= '0;
    end else if (arm) begin
      st_q <= TX_ARMED;
    end else begin
      unique case (st_q)
        TX_ARMED: if (bclk_rise_i) begin
          st_q  <= TX_SHIFT;
          sh_q  <= hold_q;
          cnt_q <= '0;
        end
        TX_SHIFT: begin
          if (bclk_rise_i && cnt_q != LAST) begin
            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
          end else if (bclk_fall_i && cnt_q == LAST) begin
            st_q <= (long_m && fs_lvl_i) ? TX_TAIL : TX_IDLE;
          end
        end
        TX_TAIL: if (fs_fall_i) st_q <= TX_IDLE;
        default: ;
      endcase
    end
  end

  assign oe_o = (st_q == TX_SHIFT) || (st_q == TX_TAIL);
  assign sd_o = sh_q[WORD_W-1];

  AST_OE_ON_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(bclk_rise_i || fs_rise_i)); // R4
  AST_OE_OFF_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> $past(bclk_fall_i || fs_fall_i || fs_rise_i)); // R5
  AST_TAIL_LONG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_TAIL) |-> long_m); // R5
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
  import pcm_port_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  frame_mode_e       mode_i,
  input  logic              bclk_fall_i,
  input  logic              fs_lvl_i,
  input  logic              fs_rise_i,
  input  logic              sd_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int unsigned CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, word_q;
  logic [CW-1:0]     cnt_q;
  logic              act_q, valid_q, arm;

  assign arm = (mode_i == FRM_LONG) ? fs_rise_i : (bclk_fall_i & fs_lvl_i);

  // the last bit of a word and the next sync may share one falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (act_q && bclk_fall_i) begin
        sh_q <= {sh_q[WORD_W-2:0], sd_i};
        if (cnt_q == LAST) begin
          act_q   <= 1'b0;
          word_q  <= {sh_q[WORD_W-2:0], sd_i};
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (arm) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R8
  AST_VALID_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(bclk_fall_i)); // R6
endmodule

// File: rtl/pcm_port_top.sv
module pcm_port_top
  import pcm_port_pkg::*;
#(
  parameter int unsigned WORD_W   = 8,
  parameter int unsigned LONG_MIN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              tx_fs_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              tx_load_i,
  output logic              tx_sd_o,
  output logic              tx_oe_o,
  output logic              slot_n_o,
  input  logic              rx_fs_i,
  input  logic              rx_sd_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              long_mode_o
);
  localparam int unsigned NL = 3;  // bit clock, tx sync, rx sync

  logic [NL-1:0] ev_rise, ev_fall;
  logic          rx_fs_fall_unused;
  frame_mode_e   mode;

  pcm_edge_det #(.N(NL)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({rx_fs_i, tx_fs_i, bclk_i}),
    .rise_o (ev_rise),
    .fall_o (ev_fall)
  );

  assign rx_fs_fall_unused = ev_fall[2];

  pcm_frame_detect #(.LONG_MIN(LONG_MIN)) u_detect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bclk_fall_i (ev_fall[0]),
    .fs_lvl_i    (tx_fs_i),
    .fs_fall_i   (ev_fall[1]),
    .mode_o      (mode)
  );

  pcm_tx_path #(.WORD_W(WORD_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .bclk_lvl_i  (bclk_i),
    .bclk_rise_i (ev_rise[0]),
    .bclk_fall_i (ev_fall[0]),
    .fs_lvl_i    (tx_fs_i),
    .fs_rise_i   (ev_rise[1]),
    .fs_fall_i   (ev_fall[1]),
    .word_i      (tx_word_i),
    .load_i      (tx_load_i),
    .sd_o        (tx_sd_o),
    .oe_o        (tx_oe_o)
  );

  pcm_rx_path #(.WORD_W(WORD_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .bclk_fall_i (ev_fall[0]),
    .fs_lvl_i    (rx_fs_i),
    .fs_rise_i   (ev_rise[2]),
    .sd_i        (rx_sd_i),
    .word_o      (rx_word_o),
    .valid_o     (rx_valid_o)
  );

  assign slot_n_o    = ~tx_oe_o;
  assign long_mode_o = (mode == FRM_LONG);
endmodule

// File: tb/pcm_port_top_tb_top.sv
module pcm_port_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bclk = 1'b0, tx_fs = 1'b0, tx_load = 1'b0, rx_fs = 1'b0, rx_sd = 1'b0;
  logic [7:0] tx_word = '0;
  logic       tx_sd_o, tx_oe_o, slot_n_o, rx_valid_o, long_mode_o;
  logic [7:0] rx_word_o;

  pcm_port_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .tx_fs_i(tx_fs),
    .tx_word_i(tx_word), .tx_load_i(tx_load), .tx_sd_o(tx_sd_o),
    .tx_oe_o(tx_oe_o), .slot_n_o(slot_n_o), .rx_fs_i(rx_fs), .rx_sd_i(rx_sd),
    .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o), .long_mode_o(long_mode_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int         n_chk = 0, n_bad = 0;
  bit         mon_en = 1'b0, done = 1'b0, pend = 1'b0;
  logic [7:0] pend_w = '0, hold_m = '0, e_w;
  logic [7:0] txq[$], rxq[$];

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // one bit period = 8 system clocks; all inputs change on negedge clk
  task automatic bit_period(input bit fs_t, input bit fs_r, input bit rb);
    bclk = 1'b1; tx_fs = fs_t; rx_fs = fs_r; rx_sd = rb;
    if (pend) begin tx_word = pend_w; tx_load = 1'b1; end
    @(negedge clk);
    tx_load = 1'b0; pend = 1'b0;
    repeat (3) @(negedge clk);
    bclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_idle(input logic [7:0] w);
    pend = 1'b1; pend_w = w; hold_m = w;
    bit_period(1'b0, 1'b0, 1'b0);
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) bit_period(1'b0, 1'b0, 1'b0);
  endtask

  // driver: short framing, both directions
  task automatic frame_short(input logic [7:0] rw, input bit mid, input logic [7:0] mw);
    if (mon_en) begin txq.push_back(hold_m); rxq.push_back(rw); end
    bit_period(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) begin
      if (mid && i == 3) begin pend = 1'b1; pend_w = mw; hold_m = mw; end
      bit_period(1'b0, 1'b0, rw[7-i]);
    end
    idles(3);
  endtask

  // driver: long framing, tx sync fs_len periods wide, rx sync 3 periods
  task automatic frame_long(input logic [7:0] rw, input int fs_len);
    int np;
    np = (fs_len > 8) ? fs_len : 8;
    if (mon_en) begin txq.push_back(hold_m); rxq.push_back(rw); end
    for (int i = 0; i < np; i++) begin
      bit_period(i < fs_len, i < 3, (i < 8) ? rw[7-i] : 1'b0);
      if (i == 7 && mon_en)
        chk(tx_oe_o == (fs_len > 8), "R5 enable state after eighth bit", tx_oe_o, fs_len > 8);
    end
    bit_period(1'b0, 1'b0, 1'b0);
    if (mon_en) chk(tx_oe_o == 1'b0, "R5 disabled once sync low", tx_oe_o, 0);
    idles(2);
  endtask

  // monitor / scoreboard, samples 1 ns after negedge clk
  logic bclk_s = 1'b0, oe_s = 1'b0, rv_s = 1'b0;
  logic [7:0] wbits = '0;
  int wcnt = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (tx_oe_o && !oe_s) wcnt = 0;
      if (bclk_s && !bclk) begin
        chk(slot_n_o == ~tx_oe_o, "R9 strobe vs enable", slot_n_o, ~tx_oe_o);
        if (tx_oe_o) begin
          wbits = {wbits[6:0], tx_sd_o};
          wcnt++;
          if (wcnt == 8) begin
            wcnt = 0;
            if (mon_en) begin
              if (txq.size() == 0) chk(1'b0, "R2 unexpected tx word", wbits, 0);
              else begin
                e_w = txq.pop_front();
                chk(wbits == e_w, "R2/R4/R10 tx word", wbits, e_w);
              end
            end
          end
        end
      end
      if (rx_valid_o && rv_s) chk(1'b0, "R8 valid wider than one cycle", 1, 0);
      if (rx_valid_o && mon_en) begin
        if (rxq.size() == 0) chk(1'b0, "R8 unexpected rx valid", rx_word_o, 0);
        else begin
          e_w = rxq.pop_front();
          chk(rx_word_o == e_w, "R6/R7/R11 rx word", rx_word_o, e_w);
        end
      end
    end
    bclk_s = bclk; oe_s = tx_oe_o; rv_s = rx_valid_o;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(tx_oe_o == 1'b0,     "R1 enable after reset", tx_oe_o, 0);
    chk(slot_n_o == 1'b1,    "R1 strobe after reset", slot_n_o, 1);
    chk(long_mode_o == 1'b0, "R1 short mode after reset", long_mode_o, 0);
    chk(rx_valid_o == 1'b0,  "R1 no valid after reset", rx_valid_o, 0);
    @(negedge clk);

    // R2 R6 R8 R9: short frames
    mon_en = 1'b1;
    load_idle(8'hA5); frame_short(8'h3C, 1'b0, 8'h00);
    load_idle(8'h00); frame_short(8'hFF, 1'b0, 8'h00);
    load_idle(8'h81); frame_short(8'h7E, 1'b0, 8'h00);
    chk(long_mode_o == 1'b0, "R3 short sync keeps short mode", long_mode_o, 0);

    // R10: load during shift goes to next frame
    load_idle(8'h5A); frame_short(8'h11, 1'b1, 8'hC3);
    frame_short(8'h22, 1'b0, 8'h00);

    // R11: second sync mid-word restarts both directions
    load_idle(8'h96);
    txq.push_back(8'h96); rxq.push_back(8'hD2);
    bit_period(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) bit_period(1'b0, 1'b0, 1'b1);
    bit_period(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) bit_period(1'b0, 1'b0, 8'hD2 >> (7 - i));
    idles(3);

    // R3: wide rx sync alone does not select long mode
    mon_en = 1'b0;
    for (int i = 0; i < 4; i++) bit_period(1'b0, 1'b1, 1'b0);
    idles(10);
    chk(long_mode_o == 1'b0, "R3 rx sync width ignored", long_mode_o, 0);

    // R3: training frame with wide tx sync
    frame_long(8'h00, 3);
    chk(long_mode_o == 1'b1, "R3 wide tx sync selects long", long_mode_o, 1);

    // R4 R5 R7: long frames
    mon_en = 1'b1;
    load_idle(8'hB7); frame_long(8'h4D, 3);
    load_idle(8'h01); frame_long(8'h80, 3);
    // R5: sync outlasting the word keeps output on
    load_idle(8'hE2); frame_long(8'h69, 10);
    chk(long_mode_o == 1'b1, "R3 mode stays long", long_mode_o, 1);

    // R4: sync rises while bit clock low
    load_idle(8'h4B);
    txq.push_back(8'h4B);
    bclk = 1'b1; tx_fs = 1'b0; rx_fs = 1'b0;
    repeat (4) @(negedge clk);
    bclk = 1'b0;
    repeat (2) @(negedge clk);
    tx_fs = 1'b1;
    @(negedge clk); #1;
    chk(tx_oe_o == 1'b0, "R4 output waits for bit-clock rise", tx_oe_o, 0);
    @(negedge clk);
    for (int i = 0; i < 8; i++) bit_period(i < 3, 1'b0, 1'b0);
    chk(tx_oe_o == 1'b0, "R5 off after eighth bit", tx_oe_o, 0);
    idles(3);

    // R3: two-period sync returns to short
    mon_en = 1'b0;
    bit_period(1'b1, 1'b0, 1'b0);
    bit_period(1'b1, 1'b0, 1'b0);
    idles(10);
    chk(long_mode_o == 1'b0, "R3 two-period sync is short", long_mode_o, 0);

    mon_en = 1'b1;
    load_idle(8'h37); frame_short(8'hC8, 1'b0, 8'h00);

    chk(txq.size() == 0, "R2 all tx words seen", txq.size(), 0);
    chk(rxq.size() == 0, "R8 all rx words seen", rxq.size(), 0);
    finish_run();
  end
endmodule